// File: doc/BRIEF.md
# Incremental Key-Lock Access Checker

This block guards a memory by keeping one small protection code, the lock, for every storage cell in a separate bank. That bank is addressed by the same host address as the main memory. Every host access carries a key alongside its address. The key is the base code of the area the address points into, advanced by the same offset as the address, modulo K = 2^W. The block reads the lock of the addressed cell in the same cycle as the access and compares it with the key. A difference raises a fault interrupt and records the offending access.

Locks within one area rise by one per cell, so the host can apply address arithmetic (a + i) to the key as well (k + i mod K) and the key stays valid. Only a privileged allocator port writes locks. Ordinary host accesses, whether opcode fetches or data transfers, never change them.

The fault recorder is a two-state machine. ARMED means no fault is held. HELD means the interrupt is raised and the record is frozen. Three transitions move it: CAPTURE (ARMED to HELD on a mismatch), RELEASE (HELD to ARMED on a clear with no mismatch), and RECAPTURE (HELD stays HELD on a clear that coincides with a mismatch, loading the new access). Any other input leaves the state unchanged.

Top module: `keylock_checker`

## Requirements
- R1: After reset the fault interrupt is low and the fault address, key and kind outputs are all zero. Every lock holds code 0, so key 0 passes at any address.
- R2: `chk_fail` is 1 in the same cycle as a strobed access whose key differs from the lock stored at the access address, and 0 when the two are equal.
- R3: Without `acc_valid`, `chk_fail` is 0 and the fault recorder does not change, whatever the key and address are.
- R4: Opcode fetches (`acc_fetch` = 1) and data accesses (`acc_fetch` = 0) are checked alike. The recorded `flt_fetch` holds the kind of the captured access.
- R5: In ARMED, a mismatch at a clock edge takes the CAPTURE transition. From the next cycle `fault_irq` is 1 and `flt_addr`, `flt_key` and `flt_fetch` hold that access.
- R6: In HELD without `fault_clr`, further mismatches leave `fault_irq` at 1 and the recorded fields unchanged.
- R7: In HELD, `fault_clr` without a mismatch takes RELEASE. The next cycle shows `fault_irq` 0 and the fields zero. `fault_clr` with a mismatch takes RECAPTURE, loading the new access.
- R8: A lock changes only through `alloc_we`, which writes `alloc_code` into cell `alloc_addr`. The new value is seen by accesses from the next cycle on. Accesses never alter any lock.
- R9: An area filled from address a with base code k, where cell a+j holds (k+j) mod 2^W, accepts key (k+i) mod 2^W at a+i for every offset in the area, including offsets where the code wraps past K-1.
- R10: An access to the cell that the allocator writes in the same cycle is compared against the lock as it was before that write.
- R11: `fault_clr` in ARMED has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Host access strobe |
| acc_fetch | input | 1 | 1 = opcode fetch, 0 = data access |
| acc_addr | input | ADDR_W | Host address of the access |
| acc_key | input | LOCK_W | Key carried with the address |
| alloc_we | input | 1 | Privileged lock write enable |
| alloc_addr | input | ADDR_W | Cell whose lock is written |
| alloc_code | input | LOCK_W | Lock code written |
| fault_clr | input | 1 | Clear request for the fault record |
| chk_fail | output | 1 | Same-cycle mismatch indication |
| fault_irq | output | 1 | Fault interrupt, high while a fault is held |
| flt_addr | output | ADDR_W | Address of the captured access |
| flt_key | output | LOCK_W | Key of the captured access |
| flt_fetch | output | 1 | Kind of the captured access |

## Verification
`chk_fail` is combinational from the access inputs and the lock array, so it is due in the cycle the access is driven. The bench samples it a quarter period after driving, well before the next rising edge. The interrupt and the fault record change at the edge that samples a mismatch or a clear, and a lock write lands at its edge. The bench therefore advances its behavioural model at that edge and compares the registered outputs a quarter period after it. Each cycle thus gets one comparison of the same-cycle result and one of the one-cycle-late results against the model's prediction.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    typedef enum logic {
        FLT_ARMED = 1'b0,
        FLT_HELD  = 1'b1
    } flt_state_e;

endpackage

// File: rtl/keylock_lockmem.sv
module keylock_lockmem #(
    parameter int ADDR_W = 6,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LOCK_W-1:0] wr_code,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LOCK_W-1:0] rd_code
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LOCK_W-1:0] cells [DEPTH];

    // Only the allocator port writes; the read is asynchronous so the
    // comparison sees the pre-write lock in a same-cycle write (R10).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_code;
        end
    end

    assign rd_code = cells[rd_addr];

endmodule

// File: rtl/keylock_compare.sv
module keylock_compare #(
    parameter int LOCK_W = 2
) (
    input  logic              strobe,
    input  logic [LOCK_W-1:0] key,
    input  logic [LOCK_W-1:0] lock,
    output logic              mismatch
);
    logic [LOCK_W-1:0] diff;

    for (genvar b = 0; b < LOCK_W; b++) begin : g_bit
        assign diff[b] = key[b] ^ lock[b];
    end

    assign mismatch = strobe & (|diff);

endmodule

// File: rtl/keylock_fault_fsm.sv
module keylock_fault_fsm
    import keylock_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mismatch,
    input  logic              clr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LOCK_W-1:0] acc_key,
    input  logic              acc_fetch,
    output logic              irq,
    output logic [ADDR_W-1:0] f_addr,
    output logic [LOCK_W-1:0] f_key,
    output logic              f_fetch
);
    flt_state_e state_q, state_d;
    logic       capture;
    logic       wipe;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        wipe    = 1'b0;
        unique case (state_q)
            FLT_ARMED: begin
                if (mismatch) begin
                    state_d = FLT_HELD;   // CAPTURE
                    capture = 1'b1;
                end
            end
            FLT_HELD: begin
                if (clr) begin
                    if (mismatch) begin
                        capture = 1'b1;   // RECAPTURE
                    end else begin
                        state_d = FLT_ARMED; // RELEASE
                        wipe    = 1'b1;
                    end
                end
            end
            default: state_d = FLT_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_addr  <= '0;
            f_key   <= '0;
            f_fetch <= 1'b0;
        end else if (capture) begin
            f_addr  <= acc_addr;
            f_key   <= acc_key;
            f_fetch <= acc_fetch;
        end else if (wipe) begin
            f_addr  <= '0;
            f_key   <= '0;
            f_fetch <= 1'b0;
        end
    end

    always_comb begin
        irq = (state_q == FLT_HELD);
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && mismatch) |=> (irq && f_addr == $past(acc_addr)
                                && f_key == $past(acc_key)
                                && f_fetch == $past(acc_fetch)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> (irq && $stable(f_addr) && $stable(f_key) && $stable(f_fetch)));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && clr && !mismatch) |=> (!irq && f_addr == '0 && f_key == '0));

    a_r11_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !mismatch) |=> (!irq && $stable(f_addr)));

endmodule

// File: rtl/keylock_checker.sv
module keylock_checker #(
    parameter int ADDR_W = 6,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_fetch,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LOCK_W-1:0] acc_key,
    input  logic              alloc_we,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [LOCK_W-1:0] alloc_code,
    input  logic              fault_clr,
    output logic              chk_fail,
    output logic              fault_irq,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [LOCK_W-1:0] flt_key,
    output logic              flt_fetch
);
    logic [LOCK_W-1:0] cell_lock;
    logic              mism;

    keylock_lockmem #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_locks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_we),
        .wr_addr (alloc_addr),
        .wr_code (alloc_code),
        .rd_addr (acc_addr),
        .rd_code (cell_lock)
    );

    keylock_compare #(.LOCK_W(LOCK_W)) u_cmp (
        .strobe   (acc_valid),
        .key      (acc_key),
        .lock     (cell_lock),
        .mismatch (mism)
    );

    keylock_fault_fsm #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mismatch  (mism),
        .clr       (fault_clr),
        .acc_addr  (acc_addr),
        .acc_key   (acc_key),
        .acc_fetch (acc_fetch),
        .irq       (fault_irq),
        .f_addr    (flt_addr),
        .f_key     (flt_key),
        .f_fetch   (flt_fetch)
    );

    assign chk_fail = mism;

    // R3: an unstrobed, uncleared cycle leaves the record untouched
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !fault_clr) |=> ($stable(fault_irq) && $stable(flt_addr)));

endmodule

// File: tb/keylock_checker_bench.sv
module keylock_checker_bench;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 6;
    localparam int LOCK_W = 2;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int KMOD   = 1 << LOCK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0, acc_fetch = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [LOCK_W-1:0] acc_key = '0;
    logic              alloc_we = 1'b0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic [LOCK_W-1:0] alloc_code = '0;
    logic              fault_clr = 1'b0;
    logic              chk_fail, fault_irq, flt_fetch;
    logic [ADDR_W-1:0] flt_addr;
    logic [LOCK_W-1:0] flt_key;

    int  checks = 0, fails = 0;
    bit  done = 0;
    int  lk [DEPTH];
    bit  m_irq = 0, m_fetch = 0;
    int  m_addr = 0, m_key = 0;

    keylock_checker #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_keylock_checker (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fetch(acc_fetch),
        .acc_addr(acc_addr), .acc_key(acc_key), .alloc_we(alloc_we),
        .alloc_addr(alloc_addr), .alloc_code(alloc_code), .fault_clr(fault_clr),
        .chk_fail(chk_fail), .fault_irq(fault_irq), .flt_addr(flt_addr),
        .flt_key(flt_key), .flt_fetch(flt_fetch)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string what, input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk("fault_irq", int'(fault_irq), int'(m_irq), tag);
        chk("flt_addr", int'(flt_addr), m_addr, tag);
        chk("flt_key", int'(flt_key), m_key, tag);
        chk("flt_fetch", int'(flt_fetch), int'(m_fetch), tag);
    endtask

    task automatic cycle(input bit v, input bit f, input int a, input int k,
                         input bit we, input int wa, input int wd,
                         input bit clr, input string tag);
        bit exp_fail;
        @(negedge clk);
        acc_valid = v; acc_fetch = f; acc_addr = a[ADDR_W-1:0]; acc_key = k[LOCK_W-1:0];
        alloc_we = we; alloc_addr = wa[ADDR_W-1:0]; alloc_code = wd[LOCK_W-1:0];
        fault_clr = clr;
        #(CLK_P/4);
        exp_fail = v && ((k % KMOD) != lk[a % DEPTH]);
        chk("chk_fail", int'(chk_fail), int'(exp_fail), tag);
        @(posedge clk);
        if (!m_irq) begin
            if (exp_fail) begin
                m_irq = 1; m_addr = a % DEPTH; m_key = k % KMOD; m_fetch = f;
            end
        end else if (clr) begin
            if (exp_fail) begin
                m_addr = a % DEPTH; m_key = k % KMOD; m_fetch = f;
            end else begin
                m_irq = 0; m_addr = 0; m_key = 0; m_fetch = 0;
            end
        end
        if (we) lk[wa % DEPTH] = wd % KMOD;
        #(CLK_P/4);
        check_regs(tag);
    endtask

    task automatic fill_area(input int base, input int len, input int code);
        for (int j = 0; j < len; j++) begin
            cycle(0, 0, 0, 0, 1, base + j, (code + j) % KMOD, 0, "R9");
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) lk[i] = 0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check_regs("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every lock resets to 0; key 0 passes everywhere
        for (int i = 0; i < DEPTH; i++) cycle(1, i % 2, i, 0, 0, 0, 0, 0, "R1");

        // R9: incremental areas, base code 3 wraps after one cell
        fill_area(16, 6, 3);
        fill_area(40, 4, 1);
        for (int i = 0; i < 6; i++) cycle(1, 0, 16 + i, (3 + i) % KMOD, 0, 0, 0, 0, "R9");
        for (int i = 0; i < 4; i++) cycle(1, 1, 40 + i, (1 + i) % KMOD, 0, 0, 0, 0, "R9");

        // R3: wrong key without strobe
        cycle(0, 0, 17, 3, 0, 0, 0, 0, "R3");
        cycle(0, 1, 40, 0, 0, 0, 0, 0, "R3");

        // R2 / R5: data mismatch at 18 (lock 1, key 0)
        cycle(1, 0, 18, 0, 0, 0, 0, 0, "R5");
        // R6: further mismatch while held
        cycle(1, 1, 41, 3, 0, 0, 0, 0, "R6");
        cycle(1, 0, 16, 3, 0, 0, 0, 0, "R6");
        // R7: release
        cycle(0, 0, 0, 0, 0, 0, 0, 1, "R7");
        // R11: clear while armed, with and without a legal access
        cycle(0, 0, 0, 0, 0, 0, 0, 1, "R11");
        cycle(1, 0, 19, 2, 0, 0, 0, 1, "R11");

        // R4: fetch mismatch at 42 (lock 3)
        cycle(1, 1, 42, 0, 0, 0, 0, 0, "R4");
        // R7: clear coinciding with a data mismatch recaptures
        cycle(1, 0, 19, 0, 0, 0, 0, 1, "R7");
        cycle(0, 0, 0, 0, 0, 0, 0, 1, "R7");

        // R10: write cell 20 while accessing it; old lock (3) applies
        cycle(1, 0, 20, 3, 1, 20, 0, 0, "R10");
        cycle(1, 0, 20, 0, 0, 0, 0, 0, "R8");
        cycle(1, 0, 20, 3, 0, 0, 0, 0, "R8");
        cycle(0, 0, 0, 0, 0, 0, 0, 1, "R8");

        // R8: accesses never alter locks
        for (int i = 0; i < 20; i++) cycle(1, 0, 16 + (i % 6), i % KMOD, 0, 0, 0, 1, "R8");
        for (int i = 0; i < DEPTH; i++) cycle(1, 0, i, lk[i], 0, 0, 0, 0, "R8");

        // R2: mixed traffic
        for (int n = 0; n < 400; n++) begin
            int ra = $urandom % DEPTH;
            int rk = (($urandom % 4) == 0) ? ($urandom % KMOD) : lk[ra];
            cycle(($urandom % 4) != 0, $urandom % 2, ra, rk,
                  ($urandom % 8) == 0, $urandom % DEPTH, $urandom % KMOD,
                  ($urandom % 3) == 0, "R2");
        end

        summary();
    end

endmodule